// File: doc/BRIEF.md
# Bidirectional Double-Buffered Handshake Port

This block is a data port whose shared pins carry traffic in both directions, with the direction chosen at run time by four handshake lines. No direction register is involved. Two two-stage buffers sit behind the pins, one for each direction. The host pushes bytes into the outbound buffer and pops bytes from the inbound buffer. The peripheral uses its own pair of handshake lines for each direction.

On the outbound side, the peripheral raises `h1` to turn on the pin drivers and see the oldest waiting byte. It lowers `h1` to show that it has taken that byte. The `h2` line tells the peripheral that outbound data is waiting. On the inbound side, a rising edge on `h3` latches the pins into the inbound buffer, and `h4` tells the peripheral that there is room for another byte. Each direction can run interlocked, where the ready line is a plain level, or pulsed, where the ready line also drops for a fixed gap after every transfer. A single service request, routed either to an interrupt line or to a DMA line, asks the host for attention.

Top module: `bidirHsPort`

## Requirements
- R1: After reset both buffers are empty, `padOe` is 0, `h2` is 0, `h4` is 1, `overrun` is 0, `outSpace` is 1 and `inAvail` is 0.
- R2: `padOe` is 1 exactly while `h1` is 1, and `padOut` always shows the oldest outbound byte not yet taken.
- R3: A host write (`hostWr` high for one clock) stores `hostWrData` in the outbound buffer, which holds up to two bytes in order. Each falling edge of `h1`, seen as a clock where `h1` is 0 after a clock where it was 1, retires the oldest byte at that clock edge.
- R4: With `outPulsed` = 0, `h2` is 1 exactly while the outbound buffer holds at least one byte.
- R5: With `outPulsed` = 1, after each retire `h2` stays 0 for GapCycles clocks (default 2), and afterwards it follows R4.
- R6: A host write while both outbound stages are full is dropped, leaving the buffer contents unchanged, and it sets `overrun`. Once set, `overrun` stays 1 until reset.
- R7: A rising edge of `h3` latches `padIn` into the inbound buffer, which holds up to two bytes. `hostRdData` shows the oldest inbound byte, and a host read (`hostRd` high for one clock) removes it.
- R8: While both inbound stages are full, a rising edge of `h3` is ignored. With `inPulsed` = 0, `h4` is 1 exactly while the inbound buffer has a free stage.
- R9: With `inPulsed` = 1, after each latch `h4` stays 0 for GapCycles clocks, and afterwards it follows R8.
- R10: A host read while the inbound buffer is empty has no effect: `inAvail` stays 0, and the next latched byte is the one that is read back.
- R11: The service condition is (inbound buffer not empty) or (outbound buffer empty). It drives `irqReq` when `useDma` = 0 and `dmaReq` when `useDma` = 1, and the other line is 0.
- R12: The two directions are independent: an inbound latch does not change `padOut` or `h2`, and a retire does not change `hostRdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe for the outbound buffer |
| hostWrData | input | W | Byte to write |
| hostRd | input | 1 | Host read strobe for the inbound buffer |
| hostRdData | output | W | Oldest inbound byte |
| outPulsed | input | 1 | 1 selects the pulsed outbound handshake |
| inPulsed | input | 1 | 1 selects the pulsed inbound handshake |
| useDma | input | 1 | Routes the service request to `dmaReq` |
| padIn | input | W | Value sensed on the data pins |
| padOut | output | W | Value driven onto the data pins |
| padOe | output | 1 | Pin driver enable |
| h1 | input | 1 | Peripheral output acknowledge and driver enable |
| h2 | output | 1 | Outbound data ready |
| h3 | input | 1 | Inbound latch strobe |
| h4 | output | 1 | Inbound room ready |
| inAvail | output | 1 | Inbound buffer not empty |
| outSpace | output | 1 | Outbound buffer has a free stage |
| overrun | output | 1 | Sticky flag for a dropped host write |
| irqReq | output | 1 | Service request on the interrupt line |
| dmaReq | output | 1 | Service request on the DMA line |

## Verification
The hardest situations to reach from the ports are the ones where a buffer is full and a new event arrives anyway: a third host write, or a third `h3` edge, before the peripheral or the host has drained anything. The directed tasks fill a buffer completely and then issue the extra event. They then drain the buffer to show that only the first two bytes come back, in order. The pulsed gap is checked clock by clock after an `h1` falling edge and after an `h3` rising edge. Independence is checked by holding outbound data while inbound bytes are latched.

// File: rtl/bidirHsPkg.sv
package bidirHsPkg;
  typedef struct packed {
    logic outPush;
    logic outPop;
    logic inPush;
    logic inPop;
    logic ovrSet;
  } hsStrobe_t;
endpackage

// File: rtl/dbBuf.sv
module dbBuf #(
  parameter int W = 8,
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count
);
  logic [W-1:0]  stage [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign doPush = push && (count < CW'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign dout   = stage[rdPtr];

  function automatic logic [PW-1:0] nextPtr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stage[i] <= '0;
      else if (doPush && wrPtr == PW'(i)) stage[i] <= din;
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (count == '0 && !push) |=> count == '0);
endmodule

// File: rtl/bidirHsData.sv
module bidirHsData
  import bidirHsPkg::*;
#(
  parameter int W = 8,
  parameter int DEPTH = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  hsStrobe_t     strobe,
  input  logic [W-1:0]  hostWrData,
  input  logic [W-1:0]  padIn,
  output logic [W-1:0]  outHead,
  output logic [W-1:0]  inHead,
  output logic [CW-1:0] outCnt,
  output logic [CW-1:0] inCnt,
  output logic          overrun
);
  dbBuf #(.W(W), .DEPTH(DEPTH)) u_outBuf (
    .clk(clk), .rstN(rstN), .push(strobe.outPush), .pop(strobe.outPop),
    .din(hostWrData), .dout(outHead), .count(outCnt));

  dbBuf #(.W(W), .DEPTH(DEPTH)) u_inBuf (
    .clk(clk), .rstN(rstN), .push(strobe.inPush), .pop(strobe.inPop),
    .din(padIn), .dout(inHead), .count(inCnt));

  always_ff @(posedge clk) begin
    if (!rstN) overrun <= 1'b0;
    else if (strobe.ovrSet) overrun <= 1'b1;
  end

  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
  a_r6_drop_keeps_count: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ovrSet && !strobe.outPop) |=> outCnt == CW'(DEPTH));
endmodule

// File: rtl/bidirHsCtrl.sv
module bidirHsCtrl
  import bidirHsPkg::*;
#(
  parameter int DEPTH = 2,
  parameter int GapCycles = 2,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int GW = $clog2(GapCycles + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic          outPulsed,
  input  logic          inPulsed,
  input  logic          useDma,
  input  logic          h1,
  input  logic          h3,
  input  logic [CW-1:0] outCnt,
  input  logic [CW-1:0] inCnt,
  output hsStrobe_t     strobe,
  output logic          padOe,
  output logic          h2,
  output logic          h4,
  output logic          irqReq,
  output logic          dmaReq
);
  logic h1Q, h3Q;
  logic [GW-1:0] outGap, inGap;
  logic outFull, inFull, svc;

  assign outFull = (outCnt == CW'(DEPTH));
  assign inFull  = (inCnt == CW'(DEPTH));

  always_comb begin
    strobe.outPush = hostWr && !outFull;
    strobe.ovrSet  = hostWr && outFull;
    strobe.outPop  = h1Q && !h1 && (outCnt != '0);
    strobe.inPush  = h3 && !h3Q && !inFull;
    strobe.inPop   = hostRd && (inCnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      h1Q    <= 1'b0;
      h3Q    <= 1'b0;
      outGap <= '0;
      inGap  <= '0;
    end else begin
      h1Q <= h1;
      h3Q <= h3;
      if (strobe.outPop && outPulsed) outGap <= GW'(GapCycles);
      else if (outGap != '0)          outGap <= outGap - 1'b1;
      if (strobe.inPush && inPulsed)  inGap <= GW'(GapCycles);
      else if (inGap != '0)           inGap <= inGap - 1'b1;
    end
  end

  assign padOe  = h1;
  assign h2     = (outCnt != '0) && (!outPulsed || outGap == '0);
  assign h4     = !inFull && (!inPulsed || inGap == '0);
  assign svc    = (inCnt != '0) || (outCnt == '0);
  assign irqReq = svc && !useDma;
  assign dmaReq = svc && useDma;

  a_r5_out_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.outPop && outPulsed) |=> !h2);
  a_r9_in_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.inPush && inPulsed) |=> !h4);
  a_r8_full_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (inFull && !hostRd) |=> inFull);
  a_r11_one_request: assert property (@(posedge clk) disable iff (!rstN)
    $countones({irqReq, dmaReq}) <= 1);
endmodule

// File: rtl/bidirHsPort.sv
module bidirHsPort
  import bidirHsPkg::*;
#(
  parameter int W = 8,
  parameter int DEPTH = 2,
  parameter int GapCycles = 2,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hostWr,
  input  logic [W-1:0] hostWrData,
  input  logic         hostRd,
  output logic [W-1:0] hostRdData,
  input  logic         outPulsed,
  input  logic         inPulsed,
  input  logic         useDma,
  input  logic [W-1:0] padIn,
  output logic [W-1:0] padOut,
  output logic         padOe,
  input  logic         h1,
  output logic         h2,
  input  logic         h3,
  output logic         h4,
  output logic         inAvail,
  output logic         outSpace,
  output logic         overrun,
  output logic         irqReq,
  output logic         dmaReq
);
  hsStrobe_t strobe;
  logic [CW-1:0] outCnt, inCnt;

  bidirHsCtrl #(.DEPTH(DEPTH), .GapCycles(GapCycles)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .outPulsed(outPulsed), .inPulsed(inPulsed), .useDma(useDma),
    .h1(h1), .h3(h3), .outCnt(outCnt), .inCnt(inCnt), .strobe(strobe),
    .padOe(padOe), .h2(h2), .h4(h4), .irqReq(irqReq), .dmaReq(dmaReq));

  bidirHsData #(.W(W), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWrData(hostWrData),
    .padIn(padIn), .outHead(padOut), .inHead(hostRdData),
    .outCnt(outCnt), .inCnt(inCnt), .overrun(overrun));

  assign inAvail  = (inCnt != '0);
  assign outSpace = (outCnt != CW'(DEPTH));

  a_r2_drive_window: assert property (@(posedge clk) disable iff (!rstN)
    (padOe && !h1) == 1'b0);
endmodule

// File: tb/bidirHsPort_bench.sv
module bidirHsPort_bench;
  localparam int ClkPeriod = 10;
  localparam int W = 8;

  logic clk = 0, rstN = 0;
  logic hostWr = 0, hostRd = 0, outPulsed = 0, inPulsed = 0, useDma = 0;
  logic h1 = 0, h3 = 0;
  logic [W-1:0] hostWrData = '0, padIn = '0;
  logic [W-1:0] hostRdData, padOut;
  logic padOe, h2, h4, inAvail, outSpace, overrun, irqReq, dmaReq;
  int checks = 0, errors = 0;

  always #(ClkPeriod/2) clk = ~clk;

  bidirHsPort u_bidirHsPort (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostWrData(hostWrData),
    .hostRd(hostRd), .hostRdData(hostRdData), .outPulsed(outPulsed),
    .inPulsed(inPulsed), .useDma(useDma), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .h1(h1), .h2(h2), .h3(h3), .h4(h4), .inAvail(inAvail),
    .outSpace(outSpace), .overrun(overrun), .irqReq(irqReq), .dmaReq(dmaReq));

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0; hostWr = 0; hostRd = 0; h1 = 0; h3 = 0;
    outPulsed = 0; inPulsed = 0; useDma = 0;
    tick(); tick(); rstN = 1; #1;
  endtask

  task automatic hostWrite(input logic [W-1:0] d);
    hostWr = 1; hostWrData = d; tick(); hostWr = 0; #1;
  endtask

  task automatic hostRead();
    hostRd = 1; tick(); hostRd = 0; #1;
  endtask

  task automatic takeByte();
    h1 = 1; tick(); h1 = 0; tick();
  endtask

  task automatic latchByte(input logic [W-1:0] d);
    padIn = d; h3 = 1; tick(); h3 = 0; tick();
  endtask

  task automatic testReset();
    doReset();
    chk("R1 padOe", padOe, 0);
    chk("R1 h2", h2, 0);
    chk("R1 h4", h4, 1);
    chk("R1 overrun", overrun, 0);
    chk("R1 outSpace", outSpace, 1);
    chk("R1 inAvail", inAvail, 0);
  endtask

  task automatic testOutInterlocked();
    doReset();
    hostWrite(8'hA1);
    chk("R4 h2 with data", h2, 1);
    chk("R2 padOut head", padOut, 8'hA1);
    hostWrite(8'hB2);
    chk("R3 full no space", outSpace, 0);
    h1 = 1; #1;
    chk("R2 oe with h1", padOe, 1);
    tick();
    chk("R2 still head", padOut, 8'hA1);
    h1 = 0; #1;
    chk("R2 oe off", padOe, 0);
    tick();
    chk("R3 retired first", padOut, 8'hB2);
    chk("R4 h2 one left", h2, 1);
    takeByte();
    chk("R4 h2 empty", h2, 0);
    chk("R3 space again", outSpace, 1);
  endtask

  task automatic testOutPulsed();
    doReset();
    outPulsed = 1;
    hostWrite(8'h11); hostWrite(8'h22);
    chk("R5 h2 before", h2, 1);
    takeByte();
    chk("R5 gap cycle1", h2, 0);
    tick();
    chk("R5 gap cycle2", h2, 0);
    tick();
    chk("R5 after gap", h2, 1);
    chk("R5 head", padOut, 8'h22);
  endtask

  task automatic testOverrun();
    doReset();
    hostWrite(8'h31); hostWrite(8'h32); hostWrite(8'h33);
    chk("R6 overrun set", overrun, 1);
    chk("R6 head kept", padOut, 8'h31);
    takeByte();
    chk("R6 second kept", padOut, 8'h32);
    takeByte();
    chk("R6 third dropped", h2, 0);
    chk("R6 sticky", overrun, 1);
  endtask

  task automatic testInput();
    doReset();
    latchByte(8'h51);
    chk("R7 avail", inAvail, 1);
    chk("R7 data", hostRdData, 8'h51);
    chk("R8 h4 room", h4, 1);
    latchByte(8'h52);
    chk("R8 h4 full", h4, 0);
    latchByte(8'h53);
    chk("R8 ignored head", hostRdData, 8'h51);
    hostRead();
    chk("R7 second", hostRdData, 8'h52);
    hostRead();
    chk("R8 third dropped", inAvail, 0);
    hostRead();
    chk("R10 empty read", inAvail, 0);
    latchByte(8'h54);
    chk("R10 next byte", hostRdData, 8'h54);
  endtask

  task automatic testInPulsed();
    doReset();
    inPulsed = 1;
    padIn = 8'h61; h3 = 1; tick(); h3 = 0;
    chk("R9 gap cycle1", h4, 0);
    tick();
    chk("R9 gap cycle2", h4, 0);
    tick();
    chk("R9 after gap", h4, 1);
  endtask

  task automatic testRequests();
    doReset();
    chk("R11 irq empty out", irqReq, 1);
    chk("R11 dma off", dmaReq, 0);
    hostWrite(8'h71);
    chk("R11 irq idle", irqReq, 0);
    latchByte(8'h72);
    chk("R11 irq in data", irqReq, 1);
    useDma = 1; #1;
    chk("R11 dma routed", dmaReq, 1);
    chk("R11 irq off", irqReq, 0);
  endtask

  task automatic testIndependence();
    doReset();
    hostWrite(8'h81);
    latchByte(8'h91);
    latchByte(8'h92);
    chk("R12 padOut kept", padOut, 8'h81);
    chk("R12 h2 kept", h2, 1);
    takeByte();
    chk("R12 rd kept", hostRdData, 8'h91);
  endtask

  initial begin
    fork
      begin
        testReset();
        testOutInterlocked();
        testOutPulsed();
        testOverrun();
        testInput();
        testInPulsed();
        testRequests();
        testIndependence();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule